// File: doc/BRIEF.md
# I2C Command Slave for an Eight-Channel Sampling Converter

This block is the serial front end of an 8-bit, 8-input sampling converter. It runs in the system clock domain, oversamples the two-wire bus lines, and answers as a slave. A master selects the converter with a write, sends one command byte, and then reads back one 8-bit result with a read. The command byte picks single-ended or differential inputs, one of eight channel codes and a two-bit power setting. The block starts the conversion while that byte is still arriving. The analog core sits outside the block: a one-cycle start pulse goes out, and a done strobe with the result word comes back.

The slave address is a fixed 5-bit prefix followed by two strap pins, which are sampled once after reset. A high-speed master code sent at normal speed puts the slave into high-speed mode. In that mode a read that arrives before the conversion is finished holds SCL low until the result is ready. The slave never drives either line high. It only pulls SDA and SCL low through output enables.

Top module: `adc_cmd_i2c_slave`

## Requirements
- R1: The slave acknowledges an address byte only when its upper seven bits equal binary 10010 followed by the latched strap pair {strap_a1, strap_a0}. Any other address is left unacknowledged.
- R2: The straps are sampled in the first clock cycle after reset and held from then on. Later changes on the strap pins do not change which address is accepted.
- R3: Address bit 0 is the direction: 0 means write and 1 means read. A read address is acknowledged only after a conversion has been started since reset.
- R4: The command byte is taken MSB first. Bit 7 drives cmd_single_ended (1 selects single-ended), bits 6..4 drive cmd_channel, bits 3..2 drive cmd_power, and bits 1..0 are ignored. The slave acknowledges the command byte.
- R5: conv_start is a single-cycle pulse. It is raised after the fourth command bit (bit 4) is sampled and before the fifth SCL rise.
- R6: A read sends the latched result MSB first, and the slave changes SDA only while SCL is low. After the master's acknowledge slot the slave releases SDA.
- R7: A first byte of the form 00001xxx received in normal-speed mode is not acknowledged and sets hs_mode.
- R8: In high-speed mode, when a read address is acknowledged while a conversion is pending, scl_oe holds SCL low until conv_done. In normal-speed mode SCL is never stretched, and the last latched result is sent.
- R9: A STOP clears hs_mode. A repeated START leaves it set.
- R10: A START or STOP in the middle of a byte abandons that byte and restarts address reception. A command byte cut short before bit 4 never raises conv_start.
- R11: A level on SCL or SDA that lasts fewer than FILT_LEN clock cycles is ignored, so such a pulse is never decoded as START or STOP. After reset both line enables are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Sensed SCL line level |
| sda_i | input | 1 | Sensed SDA line level |
| strap_a1 | input | 1 | Address strap, upper select bit |
| strap_a0 | input | 1 | Address strap, lower select bit |
| sda_oe | output | 1 | Pulls SDA low when 1 |
| scl_oe | output | 1 | Pulls SCL low (clock stretch) when 1 |
| hs_mode | output | 1 | High-speed mode active |
| conv_start | output | 1 | One-cycle conversion start pulse |
| cmd_single_ended | output | 1 | Input configuration from command bit 7 |
| cmd_channel | output | 3 | Channel code from command bits 6..4 |
| cmd_power | output | 2 | Power setting from command bits 3..2 |
| conv_done | input | 1 | Conversion finished strobe |
| conv_data | input | 8 | Conversion result, valid with conv_done |

## Verification
The bench counts SCL rises to locate the start pulse exactly. A slave that waited for the whole command byte would fire it after the eighth bit instead of the fourth. It reads in high-speed mode while a slow conversion is still pending, and also in normal-speed mode under the same condition. A design that stretched in the wrong mode would either stall the normal-speed read or return a stale byte at high speed. Further cases are a repeated START that must keep high-speed mode, a STOP placed mid-command that must suppress the start, a 2-cycle SDA spike while SCL is high that a weak filter would decode as STOP, and strap pins changed after reset, which a design sampling them continuously would follow.

// File: rtl/adc_i2c_pkg.sv
package adc_i2c_pkg;
  localparam int BYTE_W      = 8;
  localparam int CONV_AT_BIT = 4;           // command bits sampled before start
  localparam logic [4:0] ADDR_PREFIX  = 5'b10010;
  localparam logic [4:0] MCODE_PREFIX = 5'b00001;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_CMD,
    ST_CMD_ACK,
    ST_STRETCH,
    ST_TX,
    ST_TX_ACK,
    ST_SKIP
  } slv_state_t;
endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
  parameter int LINES    = 2,
  parameter int FILT_LEN = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] raw_i,
  output logic [LINES-1:0] flt_o
);
  localparam int CW = $clog2(FILT_LEN + 1);

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic          meta_q, sync_q, flt_q, flt_n;
    logic [CW-1:0] cnt_q, cnt_n;

    always_comb begin
      flt_n = flt_q;
      cnt_n = '0;
      if (sync_q != flt_q) begin
        if (cnt_q == CW'(FILT_LEN - 1)) begin
          flt_n = sync_q;
        end else begin
          cnt_n = cnt_q + 1'b1;
        end
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= 1'b1;
        sync_q <= 1'b1;
        flt_q  <= 1'b1;
        cnt_q  <= '0;
      end else begin
        meta_q <= raw_i[g];
        sync_q <= meta_q;
        flt_q  <= flt_n;
        cnt_q  <= cnt_n;
      end
    end

    assign flt_o[g] = flt_q;
  end
endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_f,
  input  logic sda_f,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
    end
  end

  assign scl_rise  = scl_f & ~scl_q;
  assign scl_fall  = ~scl_f & scl_q;
  assign start_evt = scl_f & scl_q & sda_q & ~sda_f;
  assign stop_evt  = scl_f & scl_q & ~sda_q & sda_f;
endmodule

// File: rtl/adc_i2c_slave_fsm.sv
module adc_i2c_slave_fsm
  import adc_i2c_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_f,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_evt,
  input  logic              stop_evt,
  input  logic [1:0]        sel_i,
  input  logic              conv_done_i,
  input  logic [BYTE_W-1:0] conv_data_i,
  output logic              sda_oe_o,
  output logic              scl_oe_o,
  output logic              hs_o,
  output logic              conv_start_o,
  output logic              se_o,
  output logic [2:0]        ch_o,
  output logic [1:0]        pd_o
);
  slv_state_t        state_q, state_n;
  logic [3:0]        cnt_q, cnt_n;
  logic [BYTE_W-1:0] sh_q, sh_n, res_q, res_n;
  logic              sda_oe_q, sda_oe_n, scl_oe_q, scl_oe_n;
  logic              hs_q, hs_n, rd_q, rd_n;
  logic              start_q, start_n, se_q, se_n;
  logic [2:0]        ch_q, ch_n;
  logic [1:0]        pd_q, pd_n;
  logic              seen_q, seen_n, pend_q, pend_n;
  logic              addr_hit, mcode_hit, byte_in, byte_end;

  assign addr_hit  = (sh_q[7:3] == ADDR_PREFIX) && (sh_q[2:1] == sel_i);
  assign mcode_hit = (sh_q[7:3] == MCODE_PREFIX);
  assign byte_in   = scl_rise && (cnt_q < 4'd8);
  assign byte_end  = scl_fall && (cnt_q == 4'd8);

  always_comb begin
    state_n  = state_q;
    cnt_n    = cnt_q;
    sh_n     = sh_q;
    sda_oe_n = sda_oe_q;
    scl_oe_n = scl_oe_q;
    hs_n     = hs_q;
    rd_n     = rd_q;
    start_n  = 1'b0;
    se_n     = se_q;
    ch_n     = ch_q;
    pd_n     = pd_q;
    seen_n   = seen_q;
    pend_n   = pend_q;
    res_n    = res_q;

    if (conv_done_i) begin
      res_n  = conv_data_i;
      pend_n = 1'b0;
    end

    if (stop_evt) begin
      state_n  = ST_IDLE;
      cnt_n    = '0;
      sda_oe_n = 1'b0;
      scl_oe_n = 1'b0;
      hs_n     = 1'b0;
    end else if (start_evt) begin
      state_n  = ST_ADDR;
      cnt_n    = '0;
      sda_oe_n = 1'b0;
      scl_oe_n = 1'b0;
    end else begin
      unique case (state_q)
        ST_ADDR: begin
          if (byte_in) begin
            sh_n  = {sh_q[6:0], sda_f};
            cnt_n = cnt_q + 1'b1;
          end else if (byte_end) begin
            if (addr_hit && (!sh_q[0] || seen_q)) begin
              state_n  = ST_ADDR_ACK;
              sda_oe_n = 1'b1;
              rd_n     = sh_q[0];
            end else begin
              state_n = ST_SKIP;
              if (!hs_q && mcode_hit) hs_n = 1'b1;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (scl_fall) begin
            sda_oe_n = 1'b0;
            cnt_n    = '0;
            if (!rd_q) begin
              state_n = ST_CMD;
            end else if (hs_q && pend_q) begin
              state_n  = ST_STRETCH;
              scl_oe_n = 1'b1;
            end else begin
              state_n  = ST_TX;
              sh_n     = res_q;
              sda_oe_n = ~res_q[7];
              cnt_n    = 4'd1;
            end
          end
        end
        ST_STRETCH: begin
          if (!pend_q) begin
            state_n  = ST_TX;
            scl_oe_n = 1'b0;
            sh_n     = res_q;
            sda_oe_n = ~res_q[7];
            cnt_n    = 4'd1;
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (cnt_q == 4'd8) begin
              state_n  = ST_TX_ACK;
              sda_oe_n = 1'b0;
            end else begin
              sh_n     = {sh_q[6:0], 1'b0};
              sda_oe_n = ~sh_q[6];
              cnt_n    = cnt_q + 1'b1;
            end
          end
        end
        ST_TX_ACK: begin
          if (scl_fall) state_n = ST_SKIP;
        end
        ST_CMD: begin
          if (byte_in) begin
            sh_n  = {sh_q[6:0], sda_f};
            cnt_n = cnt_q + 1'b1;
            if (cnt_q == 4'(CONV_AT_BIT - 1)) begin
              start_n = 1'b1;
              pend_n  = 1'b1;
              seen_n  = 1'b1;
              se_n    = sh_q[2];
              ch_n    = {sh_q[1:0], sda_f};
            end
          end else if (byte_end) begin
            state_n  = ST_CMD_ACK;
            sda_oe_n = 1'b1;
            pd_n     = sh_q[3:2];
          end
        end
        ST_CMD_ACK: begin
          if (scl_fall) begin
            sda_oe_n = 1'b0;
            state_n  = ST_SKIP;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      sh_q     <= '0;
      sda_oe_q <= 1'b0;
      scl_oe_q <= 1'b0;
      hs_q     <= 1'b0;
      rd_q     <= 1'b0;
      start_q  <= 1'b0;
      se_q     <= 1'b0;
      ch_q     <= '0;
      pd_q     <= '0;
      seen_q   <= 1'b0;
      pend_q   <= 1'b0;
      res_q    <= '0;
    end else begin
      state_q  <= state_n;
      cnt_q    <= cnt_n;
      sh_q     <= sh_n;
      sda_oe_q <= sda_oe_n;
      scl_oe_q <= scl_oe_n;
      hs_q     <= hs_n;
      rd_q     <= rd_n;
      start_q  <= start_n;
      se_q     <= se_n;
      ch_q     <= ch_n;
      pd_q     <= pd_n;
      seen_q   <= seen_n;
      pend_q   <= pend_n;
      res_q    <= res_n;
    end
  end

  assign sda_oe_o     = sda_oe_q;
  assign scl_oe_o     = scl_oe_q;
  assign hs_o         = hs_q;
  assign conv_start_o = start_q;
  assign se_o         = se_q;
  assign ch_o         = ch_q;
  assign pd_o         = pd_q;
endmodule

// File: rtl/adc_cmd_i2c_slave.sv
module adc_cmd_i2c_slave
  import adc_i2c_pkg::*;
#(
  parameter int FILT_LEN = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              strap_a1,
  input  logic              strap_a0,
  output logic              sda_oe,
  output logic              scl_oe,
  output logic              hs_mode,
  output logic              conv_start,
  output logic              cmd_single_ended,
  output logic [2:0]        cmd_channel,
  output logic [1:0]        cmd_power,
  input  logic              conv_done,
  input  logic [BYTE_W-1:0] conv_data
);
  logic [1:0] flt;
  logic       scl_flt, sda_flt;
  logic       scl_rise, scl_fall, start_evt, stop_evt;
  logic [1:0] sel_q;
  logic       sel_loaded_q;

  i2c_line_filter #(.LINES(2), .FILT_LEN(FILT_LEN)) filt_i (
    .clk   (clk),
    .rst_n (rst_n),
    .raw_i ({scl_i, sda_i}),
    .flt_o (flt)
  );

  assign scl_flt = flt[1];
  assign sda_flt = flt[0];

  i2c_bus_events evt_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_f     (scl_flt),
    .sda_f     (sda_flt),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_evt (start_evt),
    .stop_evt  (stop_evt)
  );

  // Straps are captured once, in the first cycle after reset.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q        <= '0;
      sel_loaded_q <= 1'b0;
    end else if (!sel_loaded_q) begin
      sel_q        <= {strap_a1, strap_a0};
      sel_loaded_q <= 1'b1;
    end
  end

  adc_i2c_slave_fsm fsm_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .sda_f        (sda_flt),
    .scl_rise     (scl_rise),
    .scl_fall     (scl_fall),
    .start_evt    (start_evt),
    .stop_evt     (stop_evt),
    .sel_i        (sel_q),
    .conv_done_i  (conv_done),
    .conv_data_i  (conv_data),
    .sda_oe_o     (sda_oe),
    .scl_oe_o     (scl_oe),
    .hs_o         (hs_mode),
    .conv_start_o (conv_start),
    .se_o         (cmd_single_ended),
    .ch_o         (cmd_channel),
    .pd_o         (cmd_power)
  );
endmodule

// File: rtl/adc_i2c_slave_chk.sv
module adc_i2c_slave_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       conv_start,
  input logic       stop_evt,
  input logic       hs_mode,
  input logic       scl_oe,
  input logic       sda_oe,
  input logic       scl_flt,
  input logic       sel_loaded_q,
  input logic [1:0] sel_q
);
  p_start_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);

  p_stop_clears_hs_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> !hs_mode);

  p_stretch_hs_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
    scl_oe |-> hs_mode);

  p_sda_moves_scl_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sda_oe) || $fell(sda_oe)) |-> !scl_flt);

  p_strap_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sel_loaded_q |=> $stable(sel_q));
endmodule

bind adc_cmd_i2c_slave adc_i2c_slave_chk chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .conv_start   (conv_start),
  .stop_evt     (stop_evt),
  .hs_mode      (hs_mode),
  .scl_oe       (scl_oe),
  .sda_oe       (sda_oe),
  .scl_flt      (scl_flt),
  .sel_loaded_q (sel_loaded_q),
  .sel_q        (sel_q)
);

// File: tb/adc_cmd_i2c_slave_tb_top.sv
`timescale 1ns/1ps
module adc_cmd_i2c_slave_tb_top;
  localparam int Q = 16;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       scl_m, sda_m;
  logic       strap_a1, strap_a0;
  logic       conv_done;
  logic [7:0] conv_data;
  logic       sda_oe, scl_oe, hs_mode, conv_start, cmd_se;
  logic [2:0] cmd_ch;
  logic [1:0] cmd_pd;
  wire        scl_line, sda_line;

  assign scl_line = scl_m & ~scl_oe;
  assign sda_line = sda_m & ~sda_oe;

  always #2.5 clk = ~clk;

  adc_cmd_i2c_slave dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
    .strap_a1(strap_a1), .strap_a0(strap_a0),
    .sda_oe(sda_oe), .scl_oe(scl_oe), .hs_mode(hs_mode),
    .conv_start(conv_start), .cmd_single_ended(cmd_se),
    .cmd_channel(cmd_ch), .cmd_power(cmd_pd),
    .conv_done(conv_done), .conv_data(conv_data)
  );

  int tests = 0, fails = 0;
  int conv_lat = 40, lat_cnt = 0, starts = 0, start_at_bit = 0;
  int bits_rised = 0, stretch_cycles = 0;
  bit busy = 0;
  logic [7:0] next_val = 8'h00;

  // converter model and monitors
  always @(negedge clk) begin
    conv_done = 1'b0;
    if (scl_oe) stretch_cycles++;
    if (conv_start) begin
      busy = 1; lat_cnt = conv_lat; starts++; start_at_bit = bits_rised;
    end else if (busy) begin
      if (lat_cnt == 0) begin
        conv_done = 1'b1; conv_data = next_val; busy = 0;
      end else lat_cnt--;
    end
  end

  task automatic check(string req, int act, int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wt(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_scl_high();
    while (scl_line !== 1'b1) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1; scl_m = 1; wt(Q);
    sda_m = 0; wt(Q);
    scl_m = 0; wt(Q);
  endtask

  task automatic bus_rstart();
    sda_m = 1; wt(Q);
    scl_m = 1; wait_scl_high(); wt(Q);
    sda_m = 0; wt(Q);
    scl_m = 0; wt(Q);
  endtask

  task automatic bus_stop();
    sda_m = 0; wt(Q);
    scl_m = 1; wait_scl_high(); wt(Q);
    sda_m = 1; wt(2*Q);
  endtask

  task automatic put_bit(logic b);
    sda_m = b; wt(Q);
    scl_m = 1; bits_rised++; wait_scl_high(); wt(2*Q);
    scl_m = 0; wt(Q);
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1; wt(Q);
    scl_m = 1; wait_scl_high(); wt(Q);
    b = sda_line; wt(Q);
    scl_m = 0; wt(Q);
  endtask

  task automatic put_byte(logic [7:0] v, output logic ack);
    logic b;
    bits_rised = 0;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(b);
    ack = ~b;
  endtask

  task automatic get_byte(output logic [7:0] v, input logic nack);
    logic b;
    for (int i = 7; i >= 0; i--) begin get_bit(b); v[i] = b; end
    put_bit(nack);
  endtask

  task automatic wait_conv_idle();
    while (busy) @(negedge clk);
    wt(4);
  endtask

  task automatic t_reset_state();
    check("R11 sda_oe after reset", sda_oe, 0);
    check("R11 scl_oe after reset", scl_oe, 0);
    check("R7 hs_mode after reset", hs_mode, 0);
    check("R5 conv_start after reset", conv_start, 0);
  endtask

  task automatic t_read_before_conv();
    logic ack;
    bus_start(); put_byte(8'h95, ack); bus_stop();
    check("R3 read NACK before any conversion", ack, 0);
  endtask

  task automatic t_write_cmd();
    logic ack; int s0;
    s0 = starts; conv_lat = 40; next_val = 8'h5A;
    bus_start(); put_byte(8'h94, ack);
    check("R1 write address ack", ack, 1);
    put_byte(8'hB4, ack);
    check("R4 command ack", ack, 1);
    check("R5 one start pulse", starts - s0, 1);
    check("R5 start after fourth bit", start_at_bit, 4);
    check("R4 single-ended field", cmd_se, 1);
    check("R4 channel field", cmd_ch, 3);
    check("R4 power field", cmd_pd, 1);
    wait_conv_idle();
  endtask

  task automatic t_fs_read();
    logic ack; logic [7:0] v;
    bus_rstart(); put_byte(8'h95, ack);
    check("R3 read address ack", ack, 1);
    get_byte(v, 1'b1);
    check("R6 read data", v, 8'h5A);
    wt(Q);
    check("R6 SDA released after NACK", sda_oe, 0);
    bus_stop();
  endtask

  task automatic t_bad_addr_and_strap();
    logic ack;
    bus_start(); put_byte(8'h9C, ack); bus_stop();
    check("R1 wrong prefix NACK", ack, 0);
    strap_a1 = 0; strap_a0 = 1; wt(4);
    bus_start(); put_byte(8'h92, ack); bus_stop();
    check("R2 new strap value not accepted", ack, 0);
    bus_start(); put_byte(8'h94, ack); bus_stop();
    check("R2 reset-time strap still accepted", ack, 1);
  endtask

  task automatic t_fs_no_stretch();
    logic ack; logic [7:0] v;
    conv_lat = 3000; next_val = 8'h3C; stretch_cycles = 0;
    bus_start(); put_byte(8'h94, ack); put_byte(8'h20, ack);
    bus_rstart(); put_byte(8'h95, ack);
    get_byte(v, 1'b1); bus_stop();
    check("R8 normal-speed read not stretched", stretch_cycles, 0);
    check("R8 normal-speed read returns last result", v, 8'h5A);
    wait_conv_idle();
  endtask

  task automatic t_hs_read();
    logic ack; logic [7:0] v;
    conv_lat = 2500; next_val = 8'hC3; stretch_cycles = 0;
    bus_start(); put_byte(8'h0B, ack);
    check("R7 master code NACK", ack, 0);
    check("R7 hs_mode set", hs_mode, 1);
    bus_rstart(); put_byte(8'h94, ack); put_byte(8'h84, ack);
    check("R4 channel zero", cmd_ch, 0);
    bus_rstart();
    check("R9 hs kept across repeated START", hs_mode, 1);
    put_byte(8'h95, ack);
    check("R3 hs read ack", ack, 1);
    get_byte(v, 1'b1);
    check("R8 hs read stretched", stretch_cycles > 100, 1);
    check("R8 hs read returns new result", v, 8'hC3);
    bus_stop();
    check("R9 STOP clears hs", hs_mode, 0);
    wait_conv_idle();
  endtask

  task automatic t_abort();
    logic ack; int s0;
    conv_lat = 40; next_val = 8'h11; s0 = starts;
    bus_start(); put_bit(1); put_bit(0); put_bit(0);
    bus_rstart(); put_byte(8'h94, ack);
    check("R10 address after aborted byte", ack, 1);
    bits_rised = 0; put_bit(1); put_bit(1);
    bus_stop();
    check("R10 no start on short command", starts - s0, 0);
    check("R10 SDA idle after abort", sda_oe, 0);
  endtask

  task automatic t_glitch();
    logic ack; int s0;
    s0 = starts;
    bus_start(); put_byte(8'h94, ack);
    bits_rised = 0; put_bit(1);
    // bit 6 = 0 with a 2-cycle high spike while SCL is high
    sda_m = 0; wt(Q); scl_m = 1; bits_rised++; wait_scl_high(); wt(Q);
    sda_m = 1; wt(2); sda_m = 0; wt(Q - 2);
    scl_m = 0; wt(Q);
    for (int i = 5; i >= 0; i--) put_bit(1'b0);
    begin logic b; get_bit(b); ack = ~b; end
    bus_stop();
    check("R11 spike not decoded as STOP", ack, 1);
    check("R11 conversion started despite spike", starts - s0, 1);
    check("R11 channel after spike", cmd_ch, 0);
    wait_conv_idle();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 0; scl_m = 1; sda_m = 1; strap_a1 = 1; strap_a0 = 0;
    conv_done = 0; conv_data = 8'h00;
    wt(10); rst_n = 1; wt(10);
    t_reset_state();
    t_read_before_conv();
    t_write_cmd();
    t_fs_read();
    t_bad_addr_and_strap();
    t_fs_no_stretch();
    t_hs_read();
    t_abort();
    t_glitch();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule